// File: doc/BRIEF.md
# Deferred-Fault Commit and Clear Unit

This unit keeps two 64-bit banks of per-register deferred-fault flags, one for integer registers and one for floating-point registers. It also keeps a small set of syndrome slots. Each slot records the destination register, the register class and the faulting address of one deferred fault. A fault-post port stands in for the load checker: it sets a flag and, when logging is on, records the fault in the lowest free slot.

Two operations act on this state, and both take effect on the clock edge of one request strobe. A *clear* only removes state. A *commit* also reports whether a deferred fault was pending. When logging is on and a fault was pending, the commit raises a one-cycle commit-exception request. An operation names either one register or every register; "every register" is written as target -1. Two inputs say whether the upper half (registers 32..63) and the lower half (registers 0..31) of the register class may be touched.

Top module: `ddc_unit`

## Requirements
- R1: After reset, both flag banks are zero, every slot is invalid with zero destination and address, and `pendOut` and `excReq` are 0.
- R2: When `postValid` is high, bit `postReg` of the bank chosen by `postFloat` becomes 1 (1 = floating-point bank). If logging is on (`ctlValid` and `ctlLog` both 1), the lowest-numbered invalid slot becomes valid and holds `postReg`, `postFloat` and `postAddr`. If no slot is free, no slot changes.
- R3: An accepted operation whose `opTarget` bit 6 is 0 clears only bit `opTarget[5:0]` of its class bank. On a commit, `pendOut` is high for the cycle after the strobe exactly when that bit was 1. A clear never raises `pendOut` or `excReq`.
- R4: An accepted operation with `opTarget` bit 6 set (-1 = 7'h7F) zeroes bits 63:32 of its class bank if `hiAvail` is 1, and bits 31:0 if `loAvail` is 1. For a commit, pending = (`hiAvail` and bits 63:32 nonzero) or (`loAvail` and bits 31:0 nonzero).
- R5: A single target is accepted only if its half is available: registers 32..63 need `hiAvail`, and registers 0..31 need `loAvail`. An all-register target needs at least one half available. A rejected operation changes no flag or slot and raises no output.
- R6: A slot is erased when all of the following hold:
  - logging is on;
  - the operation is an accepted clear, or an accepted commit whose pending was 1;
  - the slot is valid, and its class equals `opFloat`;
  - the target is all-register, or the slot's destination equals the target.

  An erased slot also has its destination and address zeroed. With logging off, no slot is erased.
- R7: `excReq` is high for the one cycle after an accepted commit exactly when logging was on and pending was 1.
- R8: An operation never changes the bank of the other class.
- R9: When a post and an operation arrive in the same cycle, the operation uses the state from before that cycle. The post's flag is set after the clear, so it survives. The post takes its slot from the slots that were free before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | Operation strobe |
| opCommit | input | 1 | 1 = commit, 0 = clear |
| opFloat | input | 1 | Register class of the operation (1 = floating-point) |
| opTarget | input | 7 | Two's-complement target; bit 6 set means all registers |
| hiAvail | input | 1 | Registers 32..63 may be touched |
| loAvail | input | 1 | Registers 0..31 may be touched |
| ctlValid | input | 1 | Logging control word is valid |
| ctlLog | input | 1 | Logging enable |
| postValid | input | 1 | Record a deferred fault |
| postFloat | input | 1 | Class of the posted fault |
| postReg | input | 6 | Destination register of the posted fault |
| postAddr | input | ADDR_W | Address of the posted fault |
| grFlags | output | 64 | Integer-class flag bank, bit i = register i |
| frFlags | output | 64 | Floating-point-class flag bank |
| slotValid | output | NUM_SLOTS | Slot valid bits |
| slotFloat | output | NUM_SLOTS | Slot class bits |
| slotDest | output | NUM_SLOTS*6 | Slot destinations, slot k at bits 6k+5:6k |
| slotAddr | output | NUM_SLOTS*ADDR_W | Slot addresses, slot k at bits ADDR_W*k upward |
| pendOut | output | 1 | Commit found a pending fault (one cycle) |
| excReq | output | 1 | Commit-exception request (one cycle) |

## Verification
A fault post and a commit or clear can land in the same cycle. They can hit the same register, the same class and the slot pool at once. The bench provokes this with a directed case: a post to a register that is being cleared in the same cycle. It also repeats such collisions throughout a long mixed sweep. Each result is judged against a bench model that applies the operation to the previous state and then applies the post. The model's flag banks, slot contents and one-cycle outputs are compared in full after every strobe.

// File: rtl/ddc_pkg.sv
package ddc_pkg;
  localparam int REG_IDX_W = 6;
  localparam int NUM_REGS  = 1 << REG_IDX_W;
  localparam int HALF_W    = NUM_REGS / 2;
  localparam int TGT_W     = REG_IDX_W + 1;

  // strobes from control to datapath
  typedef struct packed {
    logic                 apply;
    logic                 isFloat;
    logic                 allTgt;
    logic [REG_IDX_W-1:0] idx;
    logic                 clrHi;
    logic                 clrLo;
    logic                 erase;
    logic                 logAlloc;
  } strobe_t;
endpackage

// File: rtl/ddc_ctrl.sv
module ddc_ctrl
  import ddc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 opValid,
  input  logic                 opCommit,
  input  logic                 opFloat,
  input  logic [TGT_W-1:0]     opTarget,
  input  logic                 hiAvail,
  input  logic                 loAvail,
  input  logic                 ctlValid,
  input  logic                 ctlLog,
  input  logic [NUM_REGS-1:0]  grFlags,
  input  logic [NUM_REGS-1:0]  frFlags,
  output strobe_t              stb,
  output logic                 pendOut,
  output logic                 excReq
);
  logic                 allTgt;
  logic [REG_IDX_W-1:0] idx;
  logic [NUM_REGS-1:0]  bank;
  logic                 tgtAvail;
  logic                 go;
  logic                 pending;
  logic                 logOn;

  always_comb begin
    allTgt   = opTarget[TGT_W-1];
    idx      = opTarget[REG_IDX_W-1:0];
    bank     = opFloat ? frFlags : grFlags;
    tgtAvail = allTgt ? (hiAvail | loAvail)
                      : (idx[REG_IDX_W-1] ? hiAvail : loAvail);
    go       = opValid && tgtAvail;
    pending  = allTgt ? ((hiAvail && (|bank[NUM_REGS-1:HALF_W])) ||
                         (loAvail && (|bank[HALF_W-1:0])))
                      : bank[idx];
    logOn    = ctlValid && ctlLog;

    stb.apply    = go;
    stb.isFloat  = opFloat;
    stb.allTgt   = allTgt;
    stb.idx      = idx;
    stb.clrHi    = go && allTgt && hiAvail;
    stb.clrLo    = go && allTgt && loAvail;
    stb.erase    = go && logOn && (!opCommit || pending);
    stb.logAlloc = logOn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendOut <= 1'b0;
      excReq  <= 1'b0;
    end else begin
      pendOut <= go && opCommit && pending;
      excReq  <= go && opCommit && pending && logOn;
    end
  end
endmodule

// File: rtl/ddc_datapath.sv
module ddc_datapath
  import ddc_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int ADDR_W    = 32
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  strobe_t                               stb,
  input  logic                                  postValid,
  input  logic                                  postFloat,
  input  logic [REG_IDX_W-1:0]                  postReg,
  input  logic [ADDR_W-1:0]                     postAddr,
  output logic [NUM_REGS-1:0]                   grFlags,
  output logic [NUM_REGS-1:0]                   frFlags,
  output logic [NUM_SLOTS-1:0]                  slotValid,
  output logic [NUM_SLOTS-1:0]                  slotFloat,
  output logic [NUM_SLOTS-1:0][REG_IDX_W-1:0]   slotDest,
  output logic [NUM_SLOTS-1:0][ADDR_W-1:0]      slotAddr
);
  logic [NUM_REGS-1:0]  clrMask, setMask, grNext, frNext;
  logic [NUM_SLOTS-1:0] freeVec, grant, hit;
  logic                 allocGo;

  always_comb begin
    clrMask = '0;
    if (stb.apply) begin
      if (stb.allTgt) begin
        clrMask[NUM_REGS-1:HALF_W] = {HALF_W{stb.clrHi}};
        clrMask[HALF_W-1:0]        = {HALF_W{stb.clrLo}};
      end else begin
        clrMask[stb.idx] = 1'b1;
      end
    end
    setMask = '0;
    if (postValid) setMask[postReg] = 1'b1;
    // clear first, then post, so a same-cycle post survives
    grNext = (grFlags & ~(stb.isFloat ? '0 : clrMask)) | (postFloat ? '0 : setMask);
    frNext = (frFlags & ~(stb.isFloat ? clrMask : '0)) | (postFloat ? setMask : '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grFlags <= '0;
      frFlags <= '0;
    end else begin
      grFlags <= grNext;
      frFlags <= frNext;
    end
  end

  assign freeVec = ~slotValid;
  assign grant   = freeVec & (~freeVec + NUM_SLOTS'(1));
  assign allocGo = postValid && stb.logAlloc;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_hit
    assign hit[s] = stb.erase && slotValid[s] && (slotFloat[s] == stb.isFloat) &&
                    (stb.allTgt || (slotDest[s] == stb.idx));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotValid <= '0;
      slotFloat <= '0;
      slotDest  <= '0;
      slotAddr  <= '0;
    end else begin
      for (int s = 0; s < NUM_SLOTS; s++) begin
        if (hit[s]) begin
          slotValid[s] <= 1'b0;
          slotFloat[s] <= 1'b0;
          slotDest[s]  <= '0;
          slotAddr[s]  <= '0;
        end else if (allocGo && grant[s]) begin
          slotValid[s] <= 1'b1;
          slotFloat[s] <= postFloat;
          slotDest[s]  <= postReg;
          slotAddr[s]  <= postAddr;
        end
      end
    end
  end
endmodule

// File: rtl/ddc_unit.sv
module ddc_unit
  import ddc_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int ADDR_W    = 32
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           opValid,
  input  logic                           opCommit,
  input  logic                           opFloat,
  input  logic [TGT_W-1:0]               opTarget,
  input  logic                           hiAvail,
  input  logic                           loAvail,
  input  logic                           ctlValid,
  input  logic                           ctlLog,
  input  logic                           postValid,
  input  logic                           postFloat,
  input  logic [REG_IDX_W-1:0]           postReg,
  input  logic [ADDR_W-1:0]              postAddr,
  output logic [NUM_REGS-1:0]            grFlags,
  output logic [NUM_REGS-1:0]            frFlags,
  output logic [NUM_SLOTS-1:0]           slotValid,
  output logic [NUM_SLOTS-1:0]           slotFloat,
  output logic [NUM_SLOTS*REG_IDX_W-1:0] slotDest,
  output logic [NUM_SLOTS*ADDR_W-1:0]    slotAddr,
  output logic                           pendOut,
  output logic                           excReq
);
  strobe_t                                stb;
  logic [NUM_SLOTS-1:0][REG_IDX_W-1:0]    destArr;
  logic [NUM_SLOTS-1:0][ADDR_W-1:0]       addrArr;

  ddc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCommit(opCommit),
    .opFloat(opFloat), .opTarget(opTarget), .hiAvail(hiAvail), .loAvail(loAvail),
    .ctlValid(ctlValid), .ctlLog(ctlLog), .grFlags(grFlags), .frFlags(frFlags),
    .stb(stb), .pendOut(pendOut), .excReq(excReq)
  );

  ddc_datapath #(.NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .postValid(postValid),
    .postFloat(postFloat), .postReg(postReg), .postAddr(postAddr),
    .grFlags(grFlags), .frFlags(frFlags), .slotValid(slotValid),
    .slotFloat(slotFloat), .slotDest(destArr), .slotAddr(addrArr)
  );

  assign slotDest = destArr;
  assign slotAddr = addrArr;
endmodule

// File: rtl/ddc_unit_chk.sv
module ddc_unit_chk
  import ddc_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int ADDR_W    = 32
) (
  input logic                           clk,
  input logic                           rstN,
  input logic                           opValid,
  input logic                           opCommit,
  input logic                           opFloat,
  input logic [TGT_W-1:0]               opTarget,
  input logic                           hiAvail,
  input logic                           loAvail,
  input logic                           ctlValid,
  input logic                           ctlLog,
  input logic                           postValid,
  input logic                           postFloat,
  input logic [REG_IDX_W-1:0]           postReg,
  input logic [ADDR_W-1:0]              postAddr,
  input logic [NUM_REGS-1:0]            grFlags,
  input logic [NUM_REGS-1:0]            frFlags,
  input logic [NUM_SLOTS-1:0]           slotValid,
  input logic [NUM_SLOTS-1:0]           slotFloat,
  input logic [NUM_SLOTS*REG_IDX_W-1:0] slotDest,
  input logic [NUM_SLOTS*ADDR_W-1:0]    slotAddr,
  input logic                           pendOut,
  input logic                           excReq
);
  logic singleAvail;
  assign singleAvail = opTarget[REG_IDX_W-1] ? hiAvail : loAvail;

  AST_EXC_NEEDS_LOG_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    excReq |-> $past(opValid && opCommit && ctlValid && ctlLog)); // R7
  AST_EXC_WITH_PEND: assert property (@(posedge clk) disable iff (!rstN)
    excReq |-> pendOut); // R7
  AST_CLEAR_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && !opCommit) |=> (!pendOut && !excReq)); // R3
  AST_NOLOG_SLOTS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(ctlValid && ctlLog) |=> $stable(slotValid)); // R6
  AST_UNAVAIL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && !opTarget[TGT_W-1] && !singleAvail && !postValid)
      |=> ($stable(grFlags) && $stable(frFlags) && !pendOut)); // R5
  AST_SINGLE_GR_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && !opTarget[TGT_W-1] && !opFloat && singleAvail && !postValid)
      |=> (grFlags[$past(opTarget[REG_IDX_W-1:0])] == 1'b0)); // R3
  AST_POST_SETS_GR: assert property (@(posedge clk) disable iff (!rstN)
    (postValid && !postFloat) |=> grFlags[$past(postReg)]); // R2
endmodule

bind ddc_unit ddc_unit_chk #(.NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/ddc_unit_tb.sv
module ddc_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 4;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic opValid = 0, opCommit = 0, opFloat = 0, hiAvail = 0, loAvail = 0;
  logic ctlValid = 0, ctlLog = 0, postValid = 0, postFloat = 0;
  logic [6:0] opTarget = '0;
  logic [5:0] postReg = '0;
  logic [AW-1:0] postAddr = '0;
  logic [63:0] grFlags, frFlags;
  logic [NS-1:0] slotValid, slotFloat;
  logic [NS*6-1:0] slotDest;
  logic [NS*AW-1:0] slotAddr;
  logic pendOut, excReq;

  int checks = 0;
  int errors = 0;

  logic [63:0] mGr = '0, mFr = '0;
  logic [NS-1:0] mV = '0, mF = '0;
  logic [5:0] mD [NS];
  logic [AW-1:0] mA [NS];
  logic mPend = 0, mExc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ddc_unit #(.NUM_SLOTS(NS), .ADDR_W(AW)) u_dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCommit(opCommit),
    .opFloat(opFloat), .opTarget(opTarget), .hiAvail(hiAvail), .loAvail(loAvail),
    .ctlValid(ctlValid), .ctlLog(ctlLog), .postValid(postValid),
    .postFloat(postFloat), .postReg(postReg), .postAddr(postAddr),
    .grFlags(grFlags), .frFlags(frFlags), .slotValid(slotValid),
    .slotFloat(slotFloat), .slotDest(slotDest), .slotAddr(slotAddr),
    .pendOut(pendOut), .excReq(excReq)
  );

  task automatic chk(input string tag, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compareAll(input string tag);
    logic [NS*6-1:0] eD;
    logic [NS*AW-1:0] eA;
    for (int k = 0; k < NS; k++) begin
      eD[k*6 +: 6]   = mD[k];
      eA[k*AW +: AW] = mA[k];
    end
    chk(tag, "grFlags", 128'(grFlags), 128'(mGr));
    chk(tag, "frFlags", 128'(frFlags), 128'(mFr));
    chk(tag, "slotValid", 128'(slotValid), 128'(mV));
    chk(tag, "slotFloat", 128'(slotFloat), 128'(mF));
    chk(tag, "slotDest", 128'(slotDest), 128'(eD));
    chk(tag, "slotAddr", 128'(slotAddr), 128'(eA));
    chk(tag, "pendOut", 128'(pendOut), 128'(mPend));
    chk(tag, "excReq", 128'(excReq), 128'(mExc));
  endtask

  // called at a negedge; applies one cycle of stimulus and checks the result
  task automatic step(input bit oV, input bit oC, input bit oF, input logic [6:0] t,
                      input bit hi, input bit lo, input bit cv, input bit cl,
                      input bit pV, input bit pF, input logic [5:0] pr,
                      input logic [AW-1:0] pa, input string tag);
    bit all, av, go, pend, logOn, erase;
    logic [5:0] idx;
    logic [63:0] bank;
    int alloc;
    opValid = oV; opCommit = oC; opFloat = oF; opTarget = t;
    hiAvail = hi; loAvail = lo; ctlValid = cv; ctlLog = cl;
    postValid = pV; postFloat = pF; postReg = pr; postAddr = pa;
    all   = t[6];
    idx   = t[5:0];
    bank  = oF ? mFr : mGr;
    av    = all ? (hi | lo) : (idx[5] ? hi : lo);
    go    = oV && av;
    pend  = all ? ((hi && bank[63:32] != 0) || (lo && bank[31:0] != 0)) : bank[idx];
    logOn = cv && cl;
    mPend = go && oC && pend;
    mExc  = mPend && logOn;
    erase = go && logOn && (!oC || pend);
    alloc = -1;
    for (int k = NS - 1; k >= 0; k--) if (!mV[k]) alloc = k;
    if (go) begin
      if (all) begin
        if (hi) bank[63:32] = '0;
        if (lo) bank[31:0] = '0;
      end else bank[idx] = 1'b0;
      if (oF) mFr = bank; else mGr = bank;
    end
    for (int k = 0; k < NS; k++)
      if (erase && mV[k] && (mF[k] == oF) && (all || mD[k] == idx)) begin
        mV[k] = 0; mF[k] = 0; mD[k] = '0; mA[k] = '0;
      end
    if (pV) begin
      if (pF) mFr[pr] = 1'b1; else mGr[pr] = 1'b1;
      if (logOn && alloc >= 0) begin
        mV[alloc] = 1; mF[alloc] = pF; mD[alloc] = pr; mA[alloc] = pa;
      end
    end
    @(posedge clk);
    @(negedge clk);
    opValid = 0; postValid = 0;
    compareAll(tag);
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    for (int k = 0; k < NS; k++) begin mD[k] = '0; mA[k] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    compareAll("R1 reset");

    // R2: posts with logging on; the fifth finds no free slot
    step(0,0,0,7'd0,1,1,1,1, 1,0,6'd3, 32'hA000_0003, "R2 post");
    step(0,0,0,7'd0,1,1,1,1, 1,1,6'd40,32'hA000_0040, "R2 post");
    step(0,0,0,7'd0,1,1,1,1, 1,0,6'd10,32'hA000_0010, "R2 post");
    step(0,0,0,7'd0,1,1,1,1, 1,0,6'd50,32'hA000_0050, "R2 post");
    step(0,0,0,7'd0,1,1,1,1, 1,0,6'd7, 32'hA000_0007, "R2 slots full");
    // R3: single commit with logging off, then again with nothing pending
    step(1,1,0,7'd3,0,1,1,0, 0,0,6'd0,32'h0, "R3 commit pending");
    step(1,1,0,7'd3,0,1,1,0, 0,0,6'd0,32'h0, "R3 commit idle");
    // R5: register 50 is in the upper half, which is unavailable
    step(1,1,0,7'd50,0,1,1,1, 0,0,6'd0,32'h0, "R5 unavailable");
    step(1,1,0,7'h7F,0,0,1,1, 0,0,6'd0,32'h0, "R5 none available");
    // R7: logged commit raises exception and erases slot
    step(1,1,0,7'd50,1,0,1,1, 0,0,6'd0,32'h0, "R7 commit exc");
    // R6: clear with logging off keeps slots, then with logging on erases
    step(1,0,1,7'h7F,1,0,0,1, 0,0,6'd0,32'h0, "R6 clear nolog");
    step(0,0,1,7'd0,1,1,1,1, 1,1,6'd41,32'hB000_0041, "R6 repost");
    step(1,0,1,7'h7F,1,0,1,1, 0,0,6'd0,32'h0, "R6 clear erase");
    // R4: all-target commit with only the lower half available
    step(0,0,0,7'd0,1,1,1,1, 1,0,6'd60,32'hC000_0060, "R4 setup");
    step(1,1,0,7'h7F,0,1,1,1, 0,0,6'd0,32'h0, "R4 lo only");
    step(1,1,0,7'h7F,0,1,1,1, 0,0,6'd0,32'h0, "R4 lo empty");
    step(1,1,0,7'h7F,1,0,1,1, 0,0,6'd0,32'h0, "R4 hi only");
    // R8: other class untouched
    step(0,0,1,7'd0,1,1,1,1, 1,1,6'd5,32'hD000_0005, "R8 setup");
    step(1,0,0,7'h7F,1,1,1,1, 0,0,6'd0,32'h0, "R8 gr clear");
    // R9: post and clear on the same register in the same cycle
    step(0,0,0,7'd0,1,1,1,1, 1,0,6'd12,32'hE000_0012, "R9 setup");
    step(1,0,0,7'd12,1,1,1,1, 1,0,6'd12,32'hE100_0012, "R9 collide");
    step(1,1,0,7'd12,1,1,1,1, 1,0,6'd13,32'hE200_0013, "R9 commit+post");

    // mixed sweep across classes, targets, availability and logging
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r;
      logic [6:0] t;
      r = $urandom;
      t = (r[3:2] == 2'b00) ? 7'h7F : {1'b0, r[9:4]};
      step(r[10] | r[11], r[12], r[13], t, r[14] | r[15], r[16] | r[17],
           r[18] | r[19], r[20] | r[21], r[22] | r[23] | r[24], r[25], r[31:26],
           $urandom, "SWEEP R3 R4 R5 R6 R7 R8 R9");
    end
    finishRun();
  end
endmodule